// File: doc/BRIEF.md
# Compare Flags and Relative Branch Unit

This block keeps a five-bit condition register and uses it to resolve short conditional branches. When the compare strobe is high, the two operand words are compared as signed and as unsigned numbers. The result is written into the condition register on the next clock edge. Equality stands on its own: when the operands match, only the equal flag is set. Otherwise one signed ordering flag and one unsigned ordering flag are set, and equal is cleared.

When the branch strobe is high, the block decodes a 16-bit branch word that arrives with its own fetch address. It tests the word's condition against the flags currently held and returns three combinational results:
- the next program counter;
- a taken indication;
- a fault for opcodes that this form does not define.

A taken branch lands at its own address plus twice the sign-extended 10-bit offset. Every other case continues at the address plus 2.

The block has no state machine. It has two states of storage only: the reset value and the loaded flag value. The only transition is "load", which happens on a clock edge with the compare strobe high. Reset (active-low `rst_n`, asynchronous) returns the register to all zeros. Register-file access and instruction fetch belong to the surrounding pipeline.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset the flags are all zero. Branch-equal is then not taken, branch-not-equal is taken, and the eight ordering conditions are not taken.
- R2: A compare of equal operands leaves the flags at 5'b00100 (equal only). Flag bit positions are: bit 0 signed-greater, bit 1 signed-less, bit 2 equal, bit 3 unsigned-greater, bit 4 unsigned-less.
- R3: A compare of unequal operands sets exactly one of bit 0 or bit 1, chosen by the two's-complement comparison of the operands, and clears bit 2.
- R4: A compare of unequal operands also sets exactly one of bit 3 or bit 4, chosen by the unsigned comparison and independent of the signed result.
- R5: The flags change only on a clock edge where `cmp_valid` is high. A branch presented in the same cycle as a compare is resolved against the flags held before that compare.
- R6: A word with bits 15:14 = 2'b11 is a branch, and bits 13:10 select its condition. The conditions are: 0 EQ, 1 not EQ, 2 LT, 3 GT, 4 LTU, 5 GTU, 6 GT|EQ, 7 LT|EQ, 8 GTU|EQ, 9 LTU|EQ.
- R7: A branch word with opcode 10 through 15 drives `br_illegal` high, keeps `br_taken` low, and sets `next_pc` to `br_pc`+2.
- R8: A taken branch gives `next_pc` = `br_pc` + 2*sext(bits 9:0), modulo 2^32. This covers offsets +511 and -512 and wrap-around at address zero.
- R9: A branch whose condition is false gives `next_pc` = `br_pc`+2, with `br_taken` low.
- R10: With `br_valid` low, or with bits 15:14 other than 2'b11, both `br_taken` and `br_illegal` are low and `next_pc` = `br_pc`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Load the flags from this cycle's operands |
| cmp_lhs | input | 32 | Left compare operand |
| cmp_rhs | input | 32 | Right compare operand |
| br_valid | input | 1 | A branch word is presented |
| br_inst | input | 16 | Branch instruction word |
| br_pc | input | 32 | Address of the branch word |
| next_pc | output | 32 | Address of the next instruction |
| br_taken | output | 1 | Branch condition holds |
| br_illegal | output | 1 | Undefined opcode in the branch form |

## Verification
The bench builds the unit with its default widths: 32-bit operands and addresses, a 16-bit instruction word and a 10-bit offset. These widths reach the operand pairs where signed and unsigned order disagree, such as 0x80000000 against 0x7FFFFFFF and -1 against 1. They also reach both offset extremes, and targets that wrap through address zero. A behavioural model applies every condition opcode after each kind of compare, and it applies compares and branches in the same cycle to expose the one-edge latency of the flags.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
    localparam int FLAG_W   = 5;
    localparam int FLAG_GT  = 0;
    localparam int FLAG_LT  = 1;
    localparam int FLAG_EQ  = 2;
    localparam int FLAG_GTU = 3;
    localparam int FLAG_LTU = 4;

    typedef logic [FLAG_W-1:0] flags_t;

    typedef enum logic [3:0] {
        BC_EQ  = 4'd0,
        BC_NE  = 4'd1,
        BC_LT  = 4'd2,
        BC_GT  = 4'd3,
        BC_LTU = 4'd4,
        BC_GTU = 4'd5,
        BC_GE  = 4'd6,
        BC_LE  = 4'd7,
        BC_GEU = 4'd8,
        BC_LEU = 4'd9
    } br_cond_e;

    localparam logic [1:0] BRANCH_FORM = 2'b11;
endpackage

// File: rtl/cbu_flag_reg.sv
module cbu_flag_reg
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output flags_t            flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = '0;
        if (lhs == rhs) begin
            flags_d[FLAG_EQ] = 1'b1;
        end else begin
            flags_d[FLAG_GT]  = $signed(lhs) > $signed(rhs);
            flags_d[FLAG_LT]  = $signed(lhs) < $signed(rhs);
            flags_d[FLAG_GTU] = lhs > rhs;
            flags_d[FLAG_LTU] = lhs < rhs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    flags_q <= '0;
        else if (load) flags_q <= flags_d;
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic             valid,
    input  logic [1:0]       form,
    input  logic [OPC_W-1:0] opcode,
    input  flags_t           flags,
    output logic             take,
    output logic             illegal
);
    logic is_branch;
    logic hit;
    logic known;

    assign is_branch = valid && (form == BRANCH_FORM);

    always_comb begin
        hit   = 1'b0;
        known = 1'b1;
        case (opcode)
            BC_EQ:   hit = flags[FLAG_EQ];
            BC_NE:   hit = !flags[FLAG_EQ];
            BC_LT:   hit = flags[FLAG_LT];
            BC_GT:   hit = flags[FLAG_GT];
            BC_LTU:  hit = flags[FLAG_LTU];
            BC_GTU:  hit = flags[FLAG_GTU];
            BC_GE:   hit = flags[FLAG_GT]  | flags[FLAG_EQ];
            BC_LE:   hit = flags[FLAG_LT]  | flags[FLAG_EQ];
            BC_GEU:  hit = flags[FLAG_GTU] | flags[FLAG_EQ];
            BC_LEU:  hit = flags[FLAG_LTU] | flags[FLAG_EQ];
            default: known = 1'b0;
        endcase
    end

    assign take    = is_branch && known && hit;
    assign illegal = is_branch && !known;
endmodule

// File: rtl/cbu_target.sv
module cbu_target #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic              take,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int EXT_W = ADDR_W - OFF_W - 1;

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] jump_pc;

    assign disp    = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
    assign seq_pc  = pc + ADDR_W'(2);
    assign jump_pc = pc + disp;
    assign next_pc = take ? jump_pc : seq_pc;
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int INST_W = 16,
    parameter int OFF_W  = 10,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] cmp_lhs,
    input  logic [DATA_W-1:0] cmp_rhs,
    input  logic              br_valid,
    input  logic [INST_W-1:0] br_inst,
    input  logic [ADDR_W-1:0] br_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              br_taken,
    output logic              br_illegal
);
    localparam int OPC_LSB = OFF_W;
    localparam int OPC_MSB = OFF_W + OPC_W - 1;
    localparam int FRM_MSB = INST_W - 1;
    localparam int FRM_LSB = INST_W - 2;

    flags_t flags;

    cbu_flag_reg #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmp_valid),
        .lhs     (cmp_lhs),
        .rhs     (cmp_rhs),
        .flags_q (flags)
    );

    cbu_cond_eval #(.OPC_W(OPC_W)) u_cond (
        .valid   (br_valid),
        .form    (br_inst[FRM_MSB:FRM_LSB]),
        .opcode  (br_inst[OPC_MSB:OPC_LSB]),
        .flags   (flags),
        .take    (br_taken),
        .illegal (br_illegal)
    );

    cbu_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .pc      (br_pc),
        .offset  (br_inst[OFF_W-1:0]),
        .take    (br_taken),
        .next_pc (next_pc)
    );

    assert_eq_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FLAG_EQ] |-> (flags & ~(FLAG_W'(1) << FLAG_EQ)) == '0);

    assert_one_signed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags[FLAG_LT:FLAG_GT]) <= 1);

    assert_one_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0 && !flags[FLAG_EQ]) |-> $countones(flags[FLAG_LTU:FLAG_GTU]) == 1);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(flags));

    assert_illegal_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_illegal |-> (!br_taken && next_pc == br_pc + ADDR_W'(2)));

    assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> next_pc == br_pc + ADDR_W'(2));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> (!br_taken && !br_illegal));
endmodule

// File: tb/cmp_branch_unit_test.sv
`timescale 1ns/1ps
module cmp_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_lhs = '0;
    logic [31:0] cmp_rhs = '0;
    logic        br_valid = 1'b0;
    logic [15:0] br_inst = '0;
    logic [31:0] br_pc = '0;
    logic [31:0] next_pc;
    logic        br_taken;
    logic        br_illegal;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    logic [4:0] model_flags = 5'b0;

    always #2.5 clk = ~clk;

    cmp_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_lhs(cmp_lhs),
        .cmp_rhs(cmp_rhs), .br_valid(br_valid), .br_inst(br_inst), .br_pc(br_pc),
        .next_pc(next_pc), .br_taken(br_taken), .br_illegal(br_illegal)
    );

    function automatic logic [4:0] model_cmp(input logic [31:0] a, input logic [31:0] b);
        int sa = a;
        int sb = b;
        if (a == b) return 5'b00100;
        return {a < b, a > b, 1'b0, sa < sb, sa > sb};
    endfunction

    function automatic bit model_cond(input int opc, input logic [4:0] f);
        bit gt = f[0], lt = f[1], eq = f[2], gtu = f[3], ltu = f[4];
        if (opc == 0) return eq;
        if (opc == 1) return !eq;
        if (opc == 2) return lt;
        if (opc == 3) return gt;
        if (opc == 4) return ltu;
        if (opc == 5) return gtu;
        if (opc == 6) return gt || eq;
        if (opc == 7) return lt || eq;
        if (opc == 8) return gtu || eq;
        if (opc == 9) return ltu || eq;
        return 0;
    endfunction

    function automatic logic [15:0] mk_br(input int opc, input int off);
        return {2'b11, 4'(opc), 10'(off)};
    endfunction

    task automatic apply(input string tag, input bit cv, input logic [31:0] a,
                         input logic [31:0] b, input bit bv, input logic [15:0] inst,
                         input logic [31:0] pc);
        bit is_br, exp_t, exp_i;
        int opc, off;
        logic [31:0] exp_pc;
        cmp_valid = cv; cmp_lhs = a; cmp_rhs = b;
        br_valid = bv; br_inst = inst; br_pc = pc;
        #1;
        is_br = bv && inst[15:14] == 2'b11;
        opc = int'(inst[13:10]);
        off = int'(inst[9:0]);
        if (off >= 512) off = off - 1024;
        exp_i = is_br && opc >= 10;
        exp_t = is_br && opc < 10 && model_cond(opc, model_flags);
        exp_pc = exp_t ? pc + 32'(off * 2) : pc + 32'd2;
        n_vec++;
        if (br_taken !== exp_t || br_illegal !== exp_i || next_pc !== exp_pc) begin
            n_bad++;
            $display("FAIL %s inst=%h pc=%h: taken/illegal/next_pc actual %b/%b/%h expected %b/%b/%h",
                     tag, inst, pc, br_taken, br_illegal, next_pc, exp_t, exp_i, exp_pc);
        end
        @(posedge clk);
        if (cv) model_flags = model_cmp(a, b);
        @(negedge clk);
    endtask

    task automatic sweep(input string tag, input logic [31:0] pc);
        for (int k = 0; k < 10; k++) apply(tag, 0, 0, 0, 1, mk_br(k, 37 + k), pc);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset flags zero
        sweep("R1", 32'h0000_0100);
        // R2: equal operands
        apply("R2", 1, 32'd5, 32'd5, 0, 0, 0);
        sweep("R2", 32'h0000_2000);
        // R3: signed -1 < 1, unsigned greater
        apply("R3", 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0);
        sweep("R3", 32'h0000_3000);
        apply("R3", 1, 32'd9, 32'hFFFF_FFF0, 0, 0, 0);
        sweep("R3", 32'h0000_3100);
        // R4: unsigned order independent of signed
        apply("R4", 1, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, 0);
        sweep("R4", 32'h0000_4000);
        apply("R4", 1, 32'd3, 32'd7, 0, 0, 0);
        sweep("R4", 32'h0000_4100);
        // R5: same-cycle branch sees old flags (LT/LTU now), then hold
        apply("R5", 1, 32'd4, 32'd4, 1, mk_br(0, 8), 32'h5000);
        apply("R5", 0, 32'd1, 32'd2, 1, mk_br(0, 8), 32'h5000);
        apply("R5", 0, 32'd9, 32'd2, 1, mk_br(1, 8), 32'h5000);
        // R7: undefined opcodes
        for (int k = 10; k < 16; k++) apply("R7", 0, 0, 0, 1, mk_br(k, 100), 32'h7000);
        // R8: offset extremes and wrap (flags EQ -> op0 taken)
        apply("R8", 0, 0, 0, 1, mk_br(0, 511), 32'h0000_8000);
        apply("R8", 0, 0, 0, 1, mk_br(0, -512), 32'h0000_8000);
        apply("R8", 0, 0, 0, 1, mk_br(0, -512), 32'h0000_0004);
        apply("R8", 0, 0, 0, 1, mk_br(0, 2), 32'hFFFF_FFFE);
        // R9: false condition falls through
        apply("R9", 0, 0, 0, 1, mk_br(1, 200), 32'hFFFF_FFFE);
        apply("R9", 0, 0, 0, 1, mk_br(2, 200), 32'h0000_9000);
        // R10: strobe low, or non-branch form
        apply("R10", 0, 0, 0, 0, mk_br(0, 50), 32'h0000_A000);
        apply("R10", 0, 0, 0, 0, mk_br(12, 50), 32'h0000_A000);
        apply("R10", 0, 0, 0, 1, {2'b10, 4'd0, 10'd50}, 32'h0000_A000);
        apply("R10", 0, 0, 0, 1, {2'b01, 4'd11, 10'd50}, 32'h0000_A000);
        // R6: mixed random traffic
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = (k % 5 == 0) ? a : $urandom;
            logic [15:0] w = $urandom;
            if (k % 4 != 3) w[15:14] = 2'b11;
            if (k % 7 == 0) a[31] = ~b[31];
            apply("R6", k % 3 == 0, a, b, k % 9 != 0, w, $urandom);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule